// File: doc/BRIEF.md
# Circular Command Queue Pointer Controller

This block manages a ring of fixed-size command entries held in external memory. It holds the ring's start and end addresses, the producer and consumer pointers, a stop address for the consumer, two fill-level thresholds, and a running count of queued entries. A producer pulses `push_i` once for each entry it has stored at `wr_ptr`. A consumer requests an entry with `pop_i`, and `pop_ok` tells it in the same cycle whether the request is taken. Each pointer moves forward by one entry and returns to the ring start after it reaches the ring end.

A processor configures and observes the block through a 16-bit register port. Every 32-bit quantity is split into two halves. The low half sits at the register's byte offset and the high half at offset +2. Sticky level alarms and a stop-address hit flag each drive a single interrupt line, and each has its own enable. The memory traffic and the meaning of the commands are handled elsewhere.

Top module: `cmdq_ptr_ctl`

## Requirements
- R1: After reset the control register (offset 0x02) reads 0x0010, the status register (offset 0x00) reads 0x000C, all pointers, thresholds and the count read 0, and `irq` is 0.
- R2: A 32-bit register has its bits 15:0 at its byte offset and its bits 31:16 at offset +2. A write to one half leaves the other half unchanged. The offsets are: ring start 0x20, ring end 0x24, high threshold 0x28, low threshold 0x2C, count 0x30 (read-only), write pointer 0x34, read pointer 0x38, stop address 0x3C.
- R3: When control bit 4 is set, each `push_i` cycle advances the write pointer by ENTRY_BYTES and increments the count. When bit 4 is clear, a push changes neither the write pointer nor the count.
- R4: `pop_ok` is high only when `pop_i` is high, control bit 0 is set, the count is nonzero and the stop condition is not in force. Each accepted pop advances the read pointer by ENTRY_BYTES and decrements the count.
- R5: A pointer that equals the ring end when it advances takes the ring-start value instead.
- R6: The count goes up by one for an accepted push alone, down by one for an accepted pop alone, and is unchanged when both are accepted in the same cycle.
- R7: Status bit 0 sets in the cycle after the count exceeds the high threshold. It stays set until a 1 is written to bit 0 of the clear register at offset 0x04.
- R8: Status bit 1 sets in the cycle after the count is below the low threshold. It stays set until a 1 is written to bit 1 of the clear register.
- R9: While control bit 1 is set and the read pointer equals the stop address, pops are refused and status bit 4 latches. A control write with bit 1 at 0 clears status bit 4.
- R10: `irq` is high exactly when (status bit 0 and control bit 2) or (status bit 1 and control bit 3) or (status bit 4 and control bit 5).
- R11: Status bit 2 is set when control bit 0 is clear, the stop condition holds, or the count is 0. Status bit 3 is set when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset (bit 0 must be 0) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| push_i | input | 1 | Producer has stored one entry |
| pop_i | input | 1 | Consumer requests one entry |
| pop_ok | output | 1 | Pop request accepted this cycle |
| wr_ptr | output | PTR_W | Current write pointer |
| rd_ptr | output | PTR_W | Current read pointer |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps ring lengths of one to four entries and pushes past the ring end each time. A wrap off by one entry would show up as a write pointer that lands past the ring end or skips the ring start. It refuses pops on an empty queue, with reads disabled, and at the stop address. A design that let any of these through would move the read pointer and drive the count below zero. It raises each threshold flag, then removes its cause, to show that the flag is sticky, that only its own clear bit removes it, and that a flag masked by its enable stays off `irq`. It also drives a push and a pop in the same cycle, where a design that wrongly gave one of them priority would change the count.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   localparam int ADDR_W = 6;
   localparam int CTRL_W = 6;

   // control bit positions
   localparam int CT_RDEN  = 0;
   localparam int CT_STOPEN = 1;
   localparam int CT_HIIE  = 2;
   localparam int CT_LOIE  = 3;
   localparam int CT_WPINC = 4;
   localparam int CT_STOPIE = 5;
   localparam logic [CTRL_W-1:0] CTRL_RST = 6'b01_0000;

   // status bit positions
   localparam int ST_HI    = 0;
   localparam int ST_LO    = 1;
   localparam int ST_RIDLE = 2;
   localparam int ST_EMPTY = 3;
   localparam int ST_STOP  = 4;

   // word indices (byte offset / 4)
   localparam logic [3:0] W_STAT  = 4'h0;
   localparam logic [3:0] W_CLR   = 4'h1;
   localparam logic [3:0] W_COUNT = 4'hC;
   localparam logic [3:0] W_WPTR  = 4'hD;
   localparam logic [3:0] W_RPTR  = 4'hE;

   // plain config registers
   localparam int N_CFG  = 5;
   localparam int C_BASE = 0;
   localparam int C_END  = 1;
   localparam int C_HI   = 2;
   localparam int C_LO   = 3;
   localparam int C_STOP = 4;

   function automatic logic [3:0] cfg_word(input int g);
      case (g)
         C_BASE:  return 4'h8;
         C_END:   return 4'h9;
         C_HI:    return 4'hA;
         C_LO:    return 4'hB;
         default: return 4'hF;
      endcase
   endfunction

   function automatic logic [31:0] put_half(input logic [31:0] old,
                                            input logic [15:0] d,
                                            input logic upper);
      logic [31:0] r;
      r = old;
      if (upper) r[31:16] = d;
      else       r[15:0]  = d;
      return r;
   endfunction
endpackage

// File: rtl/cmdq_half_reg.sv
module cmdq_half_reg
   import cmdq_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [15:0]  wdata,
   output logic [W-1:0] q
);
   logic [31:0] merged;

   always_comb merged = put_half(32'(q), wdata, wr_hi);

   always_ff @(posedge clk) begin
      if (!rst_n)              q <= '0;
      else if (wr_lo || wr_hi) q <= merged[W-1:0];
   end
endmodule

// File: rtl/cmdq_ptr_unit.sv
module cmdq_ptr_unit
   import cmdq_pkg::*;
#(
   parameter int W    = 32,
   parameter int STEP = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [15:0]  wdata,
   input  logic         adv,
   input  logic [W-1:0] ring_start,
   input  logic [W-1:0] ring_end,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] STEP_V = W'(STEP);

   logic [31:0]  merged;
   logic [W-1:0] stepped;

   always_comb begin
      merged  = put_half(32'(q), wdata, wr_hi);
      stepped = (q == ring_end) ? ring_start : q + STEP_V;
   end

   // bus write wins over an advance in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)              q <= '0;
      else if (wr_lo || wr_hi) q <= merged[W-1:0];
      else if (adv)            q <= stepped;
   end
endmodule

// File: rtl/cmdq_level.sv
module cmdq_level #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   input  logic [W-1:0] hi_mark,
   input  logic [W-1:0] lo_mark,
   input  logic         clr_hi,
   input  logic         clr_lo,
   output logic [W-1:0] count,
   output logic         hi_flag,
   output logic         lo_flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count   <= '0;
         hi_flag <= 1'b0;
         lo_flag <= 1'b0;
      end else begin
         case ({inc, dec})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (clr_hi)                hi_flag <= 1'b0;
         else if (count > hi_mark)  hi_flag <= 1'b1;
         if (clr_lo)                lo_flag <= 1'b0;
         else if (count < lo_mark)  lo_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/cmdq_ptr_ctl.sv
module cmdq_ptr_ctl
   import cmdq_pkg::*;
#(
   parameter int PTR_W       = 32,
   parameter int ENTRY_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              push_i,
   input  logic              pop_i,
   output logic              pop_ok,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              irq
);
   if (PTR_W < 17 || PTR_W > 32) begin : g_bad_width
      $error("cmdq_ptr_ctl: PTR_W must lie in 17..32");
   end
   if (ENTRY_BYTES < 1 || (ENTRY_BYTES & (ENTRY_BYTES - 1)) != 0) begin : g_bad_entry
      $error("cmdq_ptr_ctl: ENTRY_BYTES must be a power of two");
   end

   logic [3:0]        word;
   logic              upper, wr_hit;
   logic [CTRL_W-1:0] ctrl_q;
   logic [PTR_W-1:0]  cfg_q [N_CFG];
   logic [PTR_W-1:0]  wp_q, rp_q, count_q;
   logic              hi_q, lo_q, stop_q, stall, push_acc, rd_idle;
   logic              ctrl_wr, clr_wr;
   logic [15:0]       status;

   always_comb begin
      word    = reg_addr[5:2];
      upper   = reg_addr[1];
      wr_hit  = reg_we && !reg_addr[0];
      ctrl_wr = wr_hit && word == W_STAT && upper;
      clr_wr  = wr_hit && word == W_CLR && !upper;
   end

   for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
      localparam logic [3:0] IDX = cfg_word(g);
      cmdq_half_reg #(.W(PTR_W)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_lo (wr_hit && word == IDX && !upper),
         .wr_hi (wr_hit && word == IDX && upper),
         .wdata (reg_wdata),
         .q     (cfg_q[g])
      );
   end

   always_comb begin
      stall    = ctrl_q[CT_STOPEN] && (rp_q == cfg_q[C_STOP]);
      push_acc = push_i && ctrl_q[CT_WPINC];
      pop_ok   = pop_i && ctrl_q[CT_RDEN] && !stall && (count_q != '0);
   end

   cmdq_ptr_unit #(.W(PTR_W), .STEP(ENTRY_BYTES)) u_wp (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo      (wr_hit && word == W_WPTR && !upper),
      .wr_hi      (wr_hit && word == W_WPTR && upper),
      .wdata      (reg_wdata),
      .adv        (push_acc),
      .ring_start (cfg_q[C_BASE]),
      .ring_end   (cfg_q[C_END]),
      .q          (wp_q)
   );

   cmdq_ptr_unit #(.W(PTR_W), .STEP(ENTRY_BYTES)) u_rp (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_lo      (wr_hit && word == W_RPTR && !upper),
      .wr_hi      (wr_hit && word == W_RPTR && upper),
      .wdata      (reg_wdata),
      .adv        (pop_ok),
      .ring_start (cfg_q[C_BASE]),
      .ring_end   (cfg_q[C_END]),
      .q          (rp_q)
   );

   cmdq_level #(.W(PTR_W)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (push_acc),
      .dec     (pop_ok),
      .hi_mark (cfg_q[C_HI]),
      .lo_mark (cfg_q[C_LO]),
      .clr_hi  (clr_wr && reg_wdata[0]),
      .clr_lo  (clr_wr && reg_wdata[1]),
      .count   (count_q),
      .hi_flag (hi_q),
      .lo_flag (lo_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         stop_q <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (ctrl_wr && !reg_wdata[CT_STOPEN]) stop_q <= 1'b0;
         else if (stall)                       stop_q <= 1'b1;
      end
   end

   always_comb begin
      rd_idle = !ctrl_q[CT_RDEN] || stall || (count_q == '0);
      status  = '0;
      status[ST_HI]    = hi_q;
      status[ST_LO]    = lo_q;
      status[ST_RIDLE] = rd_idle;
      status[ST_EMPTY] = (count_q == '0);
      status[ST_STOP]  = stop_q;
   end

   always_comb begin
      logic [31:0] sel;
      sel       = '0;
      reg_rdata = '0;
      case (word)
         W_STAT:  reg_rdata = upper ? 16'(ctrl_q) : status;
         W_COUNT: sel = 32'(count_q);
         W_WPTR:  sel = 32'(wp_q);
         W_RPTR:  sel = 32'(rp_q);
         default: begin
            for (int g = 0; g < N_CFG; g++)
               if (word == cfg_word(g)) sel = 32'(cfg_q[g]);
         end
      endcase
      if (word >= 4'h8) reg_rdata = upper ? sel[31:16] : sel[15:0];
   end

   always_comb begin
      irq = (hi_q && ctrl_q[CT_HIIE]) || (lo_q && ctrl_q[CT_LOIE]) ||
            (stop_q && ctrl_q[CT_STOPIE]);
      wr_ptr = wp_q;
      rd_ptr = rp_q;
   end
endmodule

// File: rtl/cmdq_ptr_ctl_chk.sv
module cmdq_ptr_ctl_chk #(
   parameter int PTR_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_we,
   input logic [5:0]       reg_addr,
   input logic [1:0]       wbits,
   input logic [5:0]       ctrl_q,
   input logic [PTR_W-1:0] count_q,
   input logic [PTR_W-1:0] wp_q,
   input logic [PTR_W-1:0] rp_q,
   input logic [PTR_W-1:0] base_q,
   input logic [PTR_W-1:0] end_q,
   input logic [PTR_W-1:0] stop_addr,
   input logic             push_acc,
   input logic             pop_ok,
   input logic             hi_q,
   input logic             lo_q,
   input logic             stop_q,
   input logic             irq
);
   logic clr_cycle;
   always_comb clr_cycle = reg_we && reg_addr == 6'h04;

   p_count_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push_acc && !pop_ok |=> count_q == $past(count_q) + 1'b1);
   p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok && !push_acc |=> count_q == $past(count_q) - 1'b1);
   p_pop_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok |-> (count_q != '0) && ctrl_q[0]);
   p_stop_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[1] && rp_q == stop_addr) |-> !pop_ok);
   p_stop_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[1] && rp_q == stop_addr && !reg_we) |=> stop_q);
   p_hi_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hi_q && !(clr_cycle && wbits[0]) |=> hi_q);
   p_lo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lo_q && !(clr_cycle && wbits[1]) |=> lo_q);
   p_rd_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop_ok && rp_q == end_q && !reg_we |=> rp_q == $past(base_q));
   p_wp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[4] && !reg_we |=> $stable(wp_q));
   p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (hi_q || lo_q || stop_q));
endmodule

bind cmdq_ptr_ctl cmdq_ptr_ctl_chk #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .wbits     (reg_wdata[1:0]),
   .ctrl_q    (ctrl_q),
   .count_q   (count_q),
   .wp_q      (wp_q),
   .rp_q      (rp_q),
   .base_q    (cfg_q[0]),
   .end_q     (cfg_q[1]),
   .stop_addr (cfg_q[4]),
   .push_acc  (push_acc),
   .pop_ok    (pop_ok),
   .hi_q      (hi_q),
   .lo_q      (lo_q),
   .stop_q    (stop_q),
   .irq       (irq)
);

// File: tb/cmdq_ptr_ctl_tb.sv
module cmdq_ptr_ctl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 32;
   localparam int EB = 32;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          reg_we = 0;
   logic [5:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          push_i = 0, pop_i = 0, pop_ok, irq;
   logic [PW-1:0] wr_ptr, rd_ptr;

   int total = 0, bad = 0;
   logic [31:0] m_base, m_end, m_wp, m_rp, m_cnt, v;
   logic [15:0] s;
   logic        ok;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmdq_ptr_ctl #(.PTR_W(PW), .ENTRY_BYTES(EB)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .push_i(push_i),
      .pop_i(pop_i), .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
      .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr16(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic wr32(input logic [5:0] a, input logic [31:0] d);
      wr16(a, d[15:0]);
      wr16(a + 6'd2, d[31:16]);
   endtask

   task automatic rd16(input logic [5:0] a, output logic [15:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd32(input logic [5:0] a, output logic [31:0] d);
      logic [15:0] lo, hi;
      rd16(a, lo);
      rd16(a + 6'd2, hi);
      d = {hi, lo};
   endtask

   task automatic cyc(input logic p, input logic q, output logic acc);
      @(negedge clk);
      push_i = p; pop_i = q;
      #1 acc = pop_ok;
      @(negedge clk);
      push_i = 0; pop_i = 0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic logic [31:0] nxt(input logic [31:0] p);
      return (p == m_end) ? m_base : p + EB;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      tick();
      // R1 reset state
      rd16(6'h02, s); chk("R1 ctrl", 32'(s), 32'h0010);
      rd16(6'h00, s); chk("R1 status", 32'(s), 32'h000C);
      rd32(6'h34, v); chk("R1 wp", v, 0);
      rd32(6'h30, v); chk("R1 count", v, 0);
      chk("R1 irq", 32'(irq), 0);

      // R2 split halves
      wr32(6'h3C, 32'hCAFEBEE0);
      rd32(6'h3C, v); chk("R2 full", v, 32'hCAFEBEE0);
      wr16(6'h3E, 16'h0102);
      rd32(6'h3C, v); chk("R2 upper only", v, 32'h0102BEE0);

      // R3/R5 sweep ring lengths 1..4 entries
      m_cnt = 0;
      m_base = 32'h0001_1000;
      for (int k = 0; k < 4; k++) begin
         m_end = m_base + 32'(EB * k);
         wr32(6'h20, m_base);
         wr32(6'h24, m_end);
         wr32(6'h34, m_base);
         m_wp = m_base;
         for (int n = 0; n < 6; n++) begin
            cyc(1, 0, ok);
            m_wp = nxt(m_wp); m_cnt++;
            rd32(6'h34, v); chk("R5 wp wrap", v, m_wp);
         end
         chk("R3 wr_ptr port", wr_ptr, m_wp);
         rd32(6'h30, v); chk("R6 count after pushes", v, m_cnt);
      end
      // R10 flag set but masked
      rd16(6'h00, s); chk("R7 hi flag set", 32'(s[0]), 1);
      chk("R10 masked irq", 32'(irq), 0);

      // R3 increment disabled
      wr16(6'h02, 16'h0000);
      cyc(1, 0, ok);
      rd32(6'h34, v); chk("R3 wp held", v, m_wp);
      rd32(6'h30, v); chk("R3 count held", v, m_cnt);

      // R4 reads disabled
      wr16(6'h02, 16'h0010);
      cyc(0, 1, ok);
      chk("R4 pop refused rden=0", 32'(ok), 0);
      rd32(6'h38, v); chk("R4 rp held", v, 0);

      // R4/R5 pops on a three-entry ring
      m_end = m_base + 32'(2 * EB);
      wr32(6'h24, m_end);
      wr32(6'h38, m_base);
      m_rp = m_base;
      wr32(6'h34, m_base); m_wp = m_base;
      wr16(6'h02, 16'h0011);
      for (int n = 0; n < 5; n++) begin
         cyc(0, 1, ok);
         chk("R4 pop accepted", 32'(ok), 1);
         m_rp = nxt(m_rp); m_cnt--;
         rd32(6'h38, v); chk("R5 rp wrap", v, m_rp);
      end
      chk("R4 rd_ptr port", rd_ptr, m_rp);
      rd32(6'h30, v); chk("R6 count after pops", v, m_cnt);

      // R6 simultaneous push and pop
      cyc(1, 1, ok);
      m_wp = nxt(m_wp); m_rp = nxt(m_rp);
      rd32(6'h30, v); chk("R6 both same cycle", v, m_cnt);
      rd32(6'h34, v); chk("R6 wp moved", v, m_wp);
      rd32(6'h38, v); chk("R6 rp moved", v, m_rp);

      // R7 high threshold
      wr32(6'h28, 32'h0000_FFFF);
      wr32(6'h2C, 0);
      wr16(6'h04, 16'h0003);
      rd16(6'h00, s); chk("R7 flags cleared", 32'(s[1:0]), 0);
      wr16(6'h28, 16'(m_cnt - 1));
      tick();
      rd16(6'h00, s); chk("R7 hi sets", 32'(s[0]), 1);
      wr16(6'h02, 16'h0015);
      chk("R10 hi irq", 32'(irq), 1);
      wr16(6'h28, 16'hFFFF);
      tick();
      rd16(6'h00, s); chk("R7 hi sticky", 32'(s[0]), 1);
      wr16(6'h04, 16'h0002);
      rd16(6'h00, s); chk("R7 wrong clear bit", 32'(s[0]), 1);
      wr16(6'h04, 16'h0001);
      rd16(6'h00, s); chk("R7 hi cleared", 32'(s[0]), 0);
      chk("R10 irq off", 32'(irq), 0);

      // R8 low threshold
      wr16(6'h2C, 16'(m_cnt + 1));
      tick();
      rd16(6'h00, s); chk("R8 lo sets", 32'(s[1]), 1);
      wr16(6'h02, 16'h0019);
      chk("R10 lo irq", 32'(irq), 1);
      wr16(6'h2C, 16'h0000);
      tick();
      rd16(6'h00, s); chk("R8 lo sticky", 32'(s[1]), 1);
      wr16(6'h04, 16'h0002);
      tick();
      rd16(6'h00, s); chk("R8 lo cleared", 32'(s[1]), 0);
      chk("R10 irq off lo", 32'(irq), 0);

      // R9 stop address
      wr32(6'h3C, nxt(m_rp));
      wr16(6'h02, 16'h0013);
      rd16(6'h00, s); chk("R9 no stop yet", 32'(s[4]), 0);
      cyc(0, 1, ok);
      chk("R9 pop before stop", 32'(ok), 1);
      m_rp = nxt(m_rp); m_cnt--;
      cyc(0, 1, ok);
      chk("R9 pop stalled", 32'(ok), 0);
      rd32(6'h38, v); chk("R9 rp held", v, m_rp);
      rd16(6'h00, s); chk("R9 stop flag", 32'(s[4]), 1);
      chk("R11 read idle at stop", 32'(s[2]), 1);
      chk("R10 stop masked", 32'(irq), 0);
      wr16(6'h02, 16'h0033);
      chk("R10 stop irq", 32'(irq), 1);
      wr16(6'h02, 16'h0011);
      rd16(6'h00, s); chk("R9 stop cleared", 32'(s[4]), 0);
      chk("R10 irq off stop", 32'(irq), 0);

      // drain, R4 empty refusal, R11
      rd16(6'h00, s); chk("R11 busy not idle", 32'(s[3:2]), 0);
      while (m_cnt != 0) begin
         cyc(0, 1, ok);
         chk("R4 drain pop", 32'(ok), 1);
         m_rp = nxt(m_rp); m_cnt--;
      end
      rd32(6'h30, v); chk("R6 drained count", v, 0);
      rd32(6'h38, v); chk("R5 rp after drain", v, m_rp);
      rd16(6'h00, s); chk("R11 empty idle", 32'(s[3:2]), 3);
      cyc(0, 1, ok);
      chk("R4 pop refused empty", 32'(ok), 0);
      rd32(6'h30, v); chk("R4 count stays 0", v, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule